// File: doc/BRIEF.md
# Brushless Motor Block-Commutation Encoder

This block turns a 9-bit mechanical rotor angle (0 to 359 degrees) into the three block-commutation phase signals of a brushless DC motor. The angle first has a zero-position correction added to it. A lead/lag correction is then applied. It is made of a fixed static part, selected by a 2-bit code, and a dynamic part written at run time over a small write port. A direction input decides whether the correction is added or subtracted. All arithmetic wraps modulo 360.

The corrected mechanical angle is multiplied by the pole-pair count and reduced modulo 360 to give the electrical angle. That angle selects one of six 60-degree sectors, and the sector drives a six-step U/V/W pattern. The direction input is asynchronous and passes through a synchronizer. Each time the synchronized direction changes, the dynamic correction is cleared, so the controller must write it again for the new direction. When the angle source reports that it has lost lock, all three phases are forced low.

Top module: `bldc_commutator`

## Requirements
- R1: The 3-bit pole-pair code selects 1, 2, 3, 4 or 5 pole pairs for codes 0 to 4. Codes 5, 6 and 7 all select 6 pole pairs.
- R2: The 2-bit static correction code selects 0, 2, 4 or 8 mechanical degrees for codes 0, 1, 2 and 3.
- R3: A cycle with the write strobe high loads the 6-bit write data (0 to 63 mechanical degrees) into the dynamic correction register, unless a direction change clears the register in that same cycle. Clearing wins over writing.
- R4: With synchronized direction 0 the static and dynamic corrections are added to the angle. With direction 1 they are subtracted.
- R5: The zero position (0 to 359) is added to the input angle before any correction is applied. Every sum and difference wraps modulo 360.
- R6: The electrical angle is (corrected angle × pole pairs) mod 360. Outputs {U,V,W} are 101 for 0–59, 100 for 60–119, 110 for 120–179, 010 for 180–239, 011 for 240–299 and 001 for 300–359, so that no valid state is 000 or 111.
- R7: When the lock input is low, all three phases are low after the next clock edge.
- R8: A change of the synchronized direction clears the dynamic correction to zero. The cleared value is already used in the cycle in which the change is seen, and it stays zero until the next write.
- R9: A change on the direction input first appears at the phase outputs after the third rising clock edge that follows it.
- R10: The phase outputs are registered: a change of angle appears after one rising clock edge.
- R11: During and directly after reset, all phases are low and the dynamic correction is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| angle | input | 9 | Mechanical angle, 0 to 359 |
| lock_ok | input | 1 | High while the angle is valid |
| zero_pos | input | 9 | Zero-position correction, 0 to 359 |
| pole_code | input | 3 | Pole-pair code (R1) |
| stat_code | input | 2 | Static correction code (R2) |
| dir_in | input | 1 | Rotation direction, asynchronous; 0 adds, 1 subtracts |
| dyn_wr_en | input | 1 | Write strobe for the dynamic correction |
| dyn_wr_data | input | 6 | Dynamic correction value, 0 to 63 |
| phase_u | output | 1 | Phase U |
| phase_v | output | 1 | Phase V |
| phase_w | output | 1 | Phase W |

## Verification
On every cycle the assertions check the following: loss of lock blanks the phases, every locked output is a legal six-step state, and the dynamic register loads, holds and clears in line with the write strobe and the direction-change event. Some behaviours can only be shown by the bench's scenarios. These are the arithmetic path (zero correction, signed correction, wrap-around, pole scaling and the sector boundaries), the exact three-edge direction latency, and the fact that a direction change takes away a correction that was written earlier. The bench compares each of these with its own model.

// File: rtl/bldc_commut_pkg.sv
package bldc_commut_pkg;
  localparam int unsigned TURN    = 360;
  localparam int unsigned ANG_W   = 9;
  localparam int unsigned WIDE_W  = 12;
  localparam int unsigned SECTOR  = TURN / 6;

  typedef logic [ANG_W-1:0]  ang_t;
  typedef logic [WIDE_W-1:0] wide_t;
  typedef logic [2:0]        phase_t;  // {U,V,W}

  // Reduce a value below 6*TURN into 0..TURN-1.
  function automatic ang_t wrap_turn(input wide_t v);
    wide_t r;
    r = v;
    for (int k = 0; k < 6; k++) begin
      if (r >= wide_t'(TURN)) r = r - wide_t'(TURN);
    end
    return r[ANG_W-1:0];
  endfunction

  function automatic logic [2:0] pole_count(input logic [2:0] code);
    return (code >= 3'd5) ? 3'd6 : code + 3'd1;
  endfunction

  function automatic ang_t stat_degrees(input logic [1:0] code);
    case (code)
      2'd0:    return ang_t'(0);
      2'd1:    return ang_t'(2);
      2'd2:    return ang_t'(4);
      default: return ang_t'(8);
    endcase
  endfunction

  function automatic phase_t sector_phases(input ang_t e);
    if      (e < ang_t'(SECTOR))     return 3'b101;
    else if (e < ang_t'(2*SECTOR))   return 3'b100;
    else if (e < ang_t'(3*SECTOR))   return 3'b110;
    else if (e < ang_t'(4*SECTOR))   return 3'b010;
    else if (e < ang_t'(5*SECTOR))   return 3'b011;
    else                             return 3'b001;
  endfunction
endpackage

// File: rtl/dir_synchronizer.sv
module dir_synchronizer #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_async,
  output logic dir_synced,
  output logic dir_change
);
  localparam int unsigned CHAIN_W = STAGES + 1;
  logic [CHAIN_W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], dir_async};
  end

  assign dir_synced = chain_q[STAGES-1];
  assign dir_change = chain_q[STAGES-1] ^ chain_q[STAGES];
endmodule

// File: rtl/dyn_offset_reg.sv
module dyn_offset_reg #(
  parameter int unsigned DYN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             wr_en,
  input  logic [DYN_W-1:0] wr_data,
  output logic [DYN_W-1:0] dyn_q,
  output logic [DYN_W-1:0] dyn_eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dyn_q <= '0;
    else if (clear) dyn_q <= '0;
    else if (wr_en) dyn_q <= wr_data;
  end

  assign dyn_eff = clear ? '0 : dyn_q;
endmodule

// File: rtl/angle_path.sv
module angle_path
  import bldc_commut_pkg::*;
#(
  parameter int unsigned DYN_W = 6
) (
  input  ang_t             angle,
  input  ang_t             zero_pos,
  input  logic [2:0]       pole_code,
  input  logic [1:0]       stat_code,
  input  logic             dir,
  input  logic [DYN_W-1:0] dyn,
  output ang_t             mech_adj,
  output ang_t             elec
);
  ang_t  base;
  wide_t offset;
  wide_t prod;

  always_comb begin
    base   = wrap_turn(wide_t'(angle) + wide_t'(zero_pos));
    offset = wide_t'(stat_degrees(stat_code)) + wide_t'(dyn);
    if (dir) mech_adj = wrap_turn(wide_t'(base) + wide_t'(TURN) - offset);
    else     mech_adj = wrap_turn(wide_t'(base) + offset);
    prod = wide_t'(mech_adj) * wide_t'(pole_count(pole_code));
    elec = wrap_turn(prod);
  end
endmodule

// File: rtl/phase_register.sv
module phase_register
  import bldc_commut_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lock_ok,
  input  ang_t elec,
  output phase_t uvw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       uvw <= '0;
    else if (lock_ok) uvw <= sector_phases(elec);
    else              uvw <= '0;
  end
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_commut_pkg::*;
#(
  parameter int unsigned DYN_W       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [8:0]       angle,
  input  logic             lock_ok,
  input  logic [8:0]       zero_pos,
  input  logic [2:0]       pole_code,
  input  logic [1:0]       stat_code,
  input  logic             dir_in,
  input  logic             dyn_wr_en,
  input  logic [DYN_W-1:0] dyn_wr_data,
  output logic             phase_u,
  output logic             phase_v,
  output logic             phase_w
);
  logic             dir_synced;
  logic             dir_change;
  logic [DYN_W-1:0] dyn_q;
  logic [DYN_W-1:0] dyn_eff;
  ang_t             mech_adj;
  ang_t             elec;
  phase_t           uvw;

  dir_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .dir_async(dir_in),
    .dir_synced(dir_synced), .dir_change(dir_change)
  );

  dyn_offset_reg #(.DYN_W(DYN_W)) u_dyn (
    .clk(clk), .rst_n(rst_n), .clear(dir_change),
    .wr_en(dyn_wr_en), .wr_data(dyn_wr_data),
    .dyn_q(dyn_q), .dyn_eff(dyn_eff)
  );

  angle_path #(.DYN_W(DYN_W)) u_path (
    .angle(angle), .zero_pos(zero_pos), .pole_code(pole_code),
    .stat_code(stat_code), .dir(dir_synced), .dyn(dyn_eff),
    .mech_adj(mech_adj), .elec(elec)
  );

  phase_register u_out (
    .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .elec(elec), .uvw(uvw)
  );

  assign {phase_u, phase_v, phase_w} = uvw;
endmodule

// File: rtl/bldc_commutator_chk.sv
module bldc_commutator_chk #(
  parameter int unsigned DYN_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lock_ok,
  input logic             dyn_wr_en,
  input logic [DYN_W-1:0] dyn_wr_data,
  input logic             dir_change,
  input logic [DYN_W-1:0] dyn_q,
  input logic             phase_u,
  input logic             phase_v,
  input logic             phase_w
);
  AST_LOCK_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_ok |=> ({phase_u, phase_v, phase_w} == 3'b000)); // R7

  AST_LEGAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    lock_ok |=> ({phase_u, phase_v, phase_w} != 3'b000 &&
                 {phase_u, phase_v, phase_w} != 3'b111)); // R6

  AST_DYN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (dyn_wr_en && !dir_change) |=> (dyn_q == $past(dyn_wr_data))); // R3

  AST_DYN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    dir_change |=> (dyn_q == '0)); // R8

  AST_DYN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_change && !dyn_wr_en) |=> $stable(dyn_q)); // R8
endmodule

bind bldc_commutator bldc_commutator_chk #(.DYN_W(DYN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lock_ok(lock_ok), .dyn_wr_en(dyn_wr_en),
  .dyn_wr_data(dyn_wr_data), .dir_change(dir_change), .dyn_q(dyn_q),
  .phase_u(phase_u), .phase_v(phase_v), .phase_w(phase_w)
);

// File: tb/sim_bldc_commutator.sv
module sim_bldc_commutator;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // fields: angle[29:21] zero[20:12] pole[11:9] stat[8:7] dir[6] dyn[5:0]
  localparam logic [29:0] VEC [NVEC] = '{
    {9'd0,   9'd0,   3'd0, 2'd0, 1'b0, 6'd0},
    {9'd59,  9'd0,   3'd0, 2'd0, 1'b0, 6'd0},
    {9'd60,  9'd0,   3'd0, 2'd0, 1'b0, 6'd0},
    {9'd200, 9'd0,   3'd1, 2'd1, 1'b0, 6'd5},
    {9'd350, 9'd20,  3'd2, 2'd2, 1'b0, 6'd10},
    {9'd10,  9'd5,   3'd3, 2'd3, 1'b1, 6'd30},
    {9'd123, 9'd300, 3'd4, 2'd1, 1'b1, 6'd63},
    {9'd77,  9'd0,   3'd5, 2'd0, 1'b1, 6'd1},
    {9'd77,  9'd0,   3'd6, 2'd0, 1'b1, 6'd1},
    {9'd77,  9'd0,   3'd7, 2'd0, 1'b1, 6'd1},
    {9'd359, 9'd359, 3'd0, 2'd3, 1'b0, 6'd63},
    {9'd299, 9'd0,   3'd0, 2'd0, 1'b0, 6'd0}
  };

  logic clk = 0, rst_n = 0;
  logic [8:0] angle = 0, zero_pos = 0;
  logic lock_ok = 0, dir_in = 0, dyn_wr_en = 0;
  logic [2:0] pole_code = 0;
  logic [1:0] stat_code = 0;
  logic [5:0] dyn_wr_data = 0;
  logic phase_u, phase_v, phase_w;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bldc_commutator u0 (
    .clk(clk), .rst_n(rst_n), .angle(angle), .lock_ok(lock_ok),
    .zero_pos(zero_pos), .pole_code(pole_code), .stat_code(stat_code),
    .dir_in(dir_in), .dyn_wr_en(dyn_wr_en), .dyn_wr_data(dyn_wr_data),
    .phase_u(phase_u), .phase_v(phase_v), .phase_w(phase_w)
  );

  function automatic logic [2:0] model(input int a, input int z, input int pc,
                                       input int sc, input int d, input int dy);
    int pp, st, m, off, adj, e, s;
    pp  = (pc > 4) ? 6 : pc + 1;
    st  = (sc == 0) ? 0 : (1 << sc);
    m   = (a + z) % 360;
    off = st + dy;
    adj = d ? (m - off + 720) % 360 : (m + off) % 360;
    e   = (adj * pp) % 360;
    s   = e / 60;
    return {s < 3, (s >= 2) && (s <= 4), (s >= 4) || (s == 0)};
  endfunction

  task automatic check(input string tag, input logic [2:0] exp);
    checks++;
    if ({phase_u, phase_v, phase_w} !== exp) begin
      errors++;
      $display("FAIL %s: uvw=%b expected %b", tag, {phase_u, phase_v, phase_w}, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [29:0] v);
    @(negedge clk);
    zero_pos = v[20:12]; pole_code = v[11:9]; stat_code = v[8:7]; lock_ok = 1;
    if (v[6] != dir_in) begin
      dir_in = v[6];
      repeat (4) @(negedge clk);
    end
    dyn_wr_en = 1; dyn_wr_data = v[5:0];
    @(negedge clk);
    dyn_wr_en = 0; angle = v[29:21];
    @(negedge clk);
    check(tag, model(v[29:21], v[20:12], v[11:9], v[8:7], v[6], v[5:0]));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check("R11 reset", 3'b000);
    rst_n = 1;
    @(negedge clk);
    check("R11 after reset, unlocked", 3'b000);

    // R6 table, also exercising R1, R2, R4, R5
    for (int i = 0; i < NVEC; i++) apply("R6 table", VEC[i]);

    // R1: codes 5..7 all give six pole pairs (angle 50 -> 300 -> 001)
    for (int c = 5; c < 8; c++) begin
      apply("R1 pole code", {9'd50, 9'd0, 3'(c), 2'd0, 1'b0, 6'd0});
      check("R1 six pairs", 3'b001);
    end
    // R2: static code 3 = 8 degrees: 55 + 8 = 63 -> sector 1
    apply("R2 static", {9'd55, 9'd0, 3'd0, 2'd3, 1'b0, 6'd0});
    check("R2 static 8deg", 3'b100);
    // R3: dynamic 63: 0 + 63 = 63 -> sector 1
    apply("R3 dyn max", {9'd0, 9'd0, 3'd0, 2'd0, 1'b0, 6'd63});
    check("R3 dyn 63", 3'b100);
    // R4: subtract: 10 - 8 - 20 = 342 -> 001
    apply("R4 subtract", {9'd10, 9'd0, 3'd0, 2'd3, 1'b1, 6'd20});
    check("R4 dir1", 3'b001);
    // R5: 300 + 100 wraps to 40 -> 101
    apply("R5 wrap", {9'd300, 9'd100, 3'd0, 2'd0, 1'b0, 6'd0});
    check("R5 zero wrap", 3'b101);

    // R8: dyn 40 applied with dir 0 (70 -> 100), cleared by dir change (30 -> 101)
    apply("R8 setup", {9'd30, 9'd0, 3'd0, 2'd0, 1'b0, 6'd40});
    check("R8 dyn before change", 3'b100);
    @(negedge clk); dir_in = 1;
    repeat (4) @(negedge clk);
    check("R8 dyn cleared", 3'b101);
    repeat (3) @(negedge clk);
    check("R8 stays cleared", 3'b101);

    // R9: angle 2, static 8: dir0 -> 10 (101); dir1 -> 354 (001)
    apply("R9 setup", {9'd2, 9'd0, 3'd0, 2'd3, 1'b0, 6'd0});
    @(negedge clk); dir_in = 1;
    @(negedge clk); check("R9 edge 1", 3'b101);
    @(negedge clk); check("R9 edge 2", 3'b101);
    @(negedge clk); check("R9 edge 3", 3'b001);

    // R10: registered output
    @(negedge clk); angle = 9'd200;  // dir1: 192 -> 010
    #1 check("R10 before edge", 3'b001);
    @(negedge clk); check("R10 after edge", 3'b010);

    // R7: lock loss
    @(negedge clk); lock_ok = 0;
    #1 check("R7 before edge", 3'b010);
    @(negedge clk); check("R7 blanked", 3'b000);
    lock_ok = 1;
    @(negedge clk); check("R7 restored", 3'b010);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule